// File: doc/BRIEF.md
# Serial-Input Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit voltage-output converter. A serial word is shifted into a staging register one bit per rising edge of the serial clock, most significant bit first, but only while the active-low select is held low. A second register supplies the code to the converter. It is a level-sensitive latch: it is open while the active-low load strobe is low and closed while the strobe is high. A new value can therefore be staged without any change to the present output.

An asynchronous active-low clear forces the output code to zero at any time. For checking, the block also reports the ideal output voltage in microvolts, at 500 uV per code step. A shift that happens while the load strobe is low breaks the protocol. The shift still takes effect, but the block raises a violation flag.

Top module: `dac_serial_frontend`

## Requirements
- R1: While `clr_n` is low, `dac_code` is 0, asynchronously, whatever `cs_n`, `sclk` and `sdi` do.
- R2: On each rising edge of `sclk` with `cs_n` low, the 12-bit staging register moves one place toward its MSB and takes `sdi` into bit 0. Twelve edges therefore stage a word sent MSB first.
- R3: With `cs_n` high, edges of `sclk` leave the staging register unchanged.
- R4: While `ld_n` is low and `clr_n` is high, `dac_code` equals the staging register and follows it.
- R5: While `ld_n` is high, `dac_code` keeps the value it had when `ld_n` rose, even when serial shifting goes on.
- R6: When `clr_n` rises with `ld_n` high, `dac_code` stays 0.
- R7: A rising `sclk` edge with `cs_n` low and `ld_n` low still shifts, and `dac_code` follows the result. `shift_viol` is then high for the clock period after that edge. It is low after any edge where `cs_n` or `ld_n` is high, and low while `clr_n` is low.
- R8: `vout_uv` equals `dac_code` × 500 as an unsigned 21-bit value. Examples: 0xFFF gives 2047500, 0x800 gives 1024000, 0x7FF gives 1023500, 0x000 gives 0.
- R9: When `clr_n` and `ld_n` are both low, the clear wins and `dac_code` is 0. When `clr_n` rises while `ld_n` is still low, `dac_code` takes the staging value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| cs_n | input | 1 | Active-low select that enables shifting |
| sdi | input | 1 | Serial data, MSB first |
| ld_n | input | 1 | Active-low level-sensitive load strobe |
| clr_n | input | 1 | Active-low asynchronous clear of the output code |
| dac_code | output | 12 | Code held for the converter |
| vout_uv | output | 21 | Ideal output voltage in microvolts |
| shift_viol | output | 1 | Shift happened while the load strobe was low |

## Verification
The staging register cannot be seen directly. A wrong bit in it shows on `dac_code` only when `ld_n` next goes low, so each staged word is checked right after a load pulse. A shift that is lost or taken without cause shows up as a code moved by one place or as a changed held value. While the latch is closed, any change of `dac_code` within a clock period is an error. The clear and the latch are checked a moment after their control pin changes and again after a clock edge, to catch a clear that waits for a clock. The violation flag is checked in the period right after the offending edge and again one edge later.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int CODE_W_DEF = 12;
  localparam int UV_STEP_DEF = 500;

  function automatic int uv_bits(input int code_w, input int step);
    longint top;
    top = ((longint'(1) << code_w) - 1) * step;
    return $clog2(top + 1);
  endfunction

  function automatic logic [31:0] scale_uv(input logic [31:0] code, input int step);
    return code * 32'(step);
  endfunction
endpackage

// File: rtl/dac_shift_stage.sv
module dac_shift_stage #(
  parameter int CODE_W = 12
) (
  input  logic              sclk,
  input  logic              shift_en,
  input  logic              sdi,
  output logic [CODE_W-1:0] stage_q
);
  logic [CODE_W-1:0] stage_r;

  always_ff @(posedge sclk) begin
    if (shift_en) stage_r <= {stage_r[CODE_W-2:0], sdi};
  end

  assign stage_q = stage_r;
endmodule

// File: rtl/dac_hold_latch.sv
module dac_hold_latch #(
  parameter int CODE_W = 12
) (
  input  logic              clr_n,
  input  logic              open_n,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);
  logic [CODE_W-1:0] hold_r;

  always_latch begin
    if (!clr_n)      hold_r = '0;
    else if (!open_n) hold_r = d;
  end

  assign q = hold_r;
endmodule

// File: rtl/dac_viol_flag.sv
module dac_viol_flag (
  input  logic sclk,
  input  logic clr_n,
  input  logic shift_en,
  input  logic latch_open,
  output logic viol
);
  logic viol_r;

  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) viol_r <= 1'b0;
    else        viol_r <= shift_en && latch_open;
  end

  assign viol = viol_r;
endmodule

// File: rtl/dac_uv_scale.sv
module dac_uv_scale #(
  parameter int CODE_W  = 12,
  parameter int UV_STEP = 500,
  parameter int UV_W    = 21
) (
  input  logic [CODE_W-1:0] code,
  output logic [UV_W-1:0]   uv
);
  logic [31:0] uv_full;

  assign uv_full = dac_pkg::scale_uv(32'(code), UV_STEP);
  assign uv      = uv_full[UV_W-1:0];
endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend #(
  parameter int CODE_W  = dac_pkg::CODE_W_DEF,
  parameter int UV_STEP = dac_pkg::UV_STEP_DEF,
  localparam int UV_W   = dac_pkg::uv_bits(CODE_W, UV_STEP)
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              ld_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] dac_code,
  output logic [UV_W-1:0]   vout_uv,
  output logic              shift_viol
);
  // named internal events for the checker
  logic              shift_en;
  logic              latch_open;
  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] hold_q;

  assign shift_en   = !cs_n;
  assign latch_open = !ld_n;

  dac_shift_stage #(.CODE_W(CODE_W)) u_stage (
    .sclk     (sclk),
    .shift_en (shift_en),
    .sdi      (sdi),
    .stage_q  (stage_q)
  );

  dac_hold_latch #(.CODE_W(CODE_W)) u_hold (
    .clr_n  (clr_n),
    .open_n (ld_n),
    .d      (stage_q),
    .q      (hold_q)
  );

  dac_viol_flag u_viol (
    .sclk       (sclk),
    .clr_n      (clr_n),
    .shift_en   (shift_en),
    .latch_open (latch_open),
    .viol       (shift_viol)
  );

  dac_uv_scale #(.CODE_W(CODE_W), .UV_STEP(UV_STEP), .UV_W(UV_W)) u_scale (
    .code (hold_q),
    .uv   (vout_uv)
  );

  assign dac_code = hold_q;
endmodule

// File: rtl/dac_serial_frontend_chk.sv
module dac_serial_frontend_chk #(
  parameter int CODE_W = 12
) (
  input logic              sclk,
  input logic              cs_n,
  input logic              sdi,
  input logic              ld_n,
  input logic              clr_n,
  input logic [CODE_W-1:0] stage_q,
  input logic [CODE_W-1:0] dac_code,
  input logic              shift_viol
);
  AST_CLEAR_FORCES_ZERO: assert property (@(posedge sclk) !clr_n |-> (dac_code == '0)); // R1
  AST_SHIFT_MSB_FIRST: assert property (@(posedge sclk) disable iff (!clr_n)
    !cs_n |=> (stage_q == {$past(stage_q[CODE_W-2:0]), $past(sdi)})); // R2
  AST_DESELECT_HOLDS: assert property (@(posedge sclk) disable iff (!clr_n)
    cs_n |=> $stable(stage_q)); // R3
  AST_OPEN_FOLLOWS: assert property (@(posedge sclk) disable iff (!clr_n)
    !ld_n |-> (dac_code == stage_q)); // R4
  AST_CLOSED_HOLDS: assert property (@(posedge sclk) disable iff (!clr_n)
    (ld_n && $past(ld_n) && $past(clr_n)) |-> $stable(dac_code)); // R5
  AST_VIOL_RAISED: assert property (@(posedge sclk) disable iff (!clr_n)
    (!cs_n && !ld_n) |=> shift_viol); // R7
  AST_VIOL_QUIET: assert property (@(posedge sclk) disable iff (!clr_n)
    (cs_n || ld_n) |=> !shift_viol); // R7
endmodule

bind dac_serial_frontend dac_serial_frontend_chk #(.CODE_W(CODE_W)) u_chk (
  .sclk       (sclk),
  .cs_n       (cs_n),
  .sdi        (sdi),
  .ld_n       (ld_n),
  .clr_n      (clr_n),
  .stage_q    (stage_q),
  .dac_code   (dac_code),
  .shift_viol (shift_viol)
);

// File: tb/tb_dac_serial_frontend.sv
`timescale 1ns/1ps
module tb_dac_serial_frontend;
  localparam int W = 12;
  logic sclk = 1'b0;
  logic cs_n, sdi, ld_n, clr_n;
  logic [W-1:0] dac_code;
  logic [20:0]  vout_uv;
  logic         shift_viol;
  int n_run = 0;
  int n_fail = 0;

  always #2 sclk = ~sclk;

  dac_serial_frontend dut (
    .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .ld_n(ld_n), .clr_n(clr_n),
    .dac_code(dac_code), .vout_uv(vout_uv), .shift_viol(shift_viol)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_code(input string req, input int exp);
    chk(req, "dac_code", int'(dac_code), exp);
    chk("R8", "vout_uv", int'(vout_uv), exp * 500);
  endtask

  task automatic shift_word(input logic [W-1:0] v);
    cs_n = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      sdi = v[i];
      @(posedge sclk); @(negedge sclk);
    end
    cs_n = 1'b1;
  endtask

  task automatic load_pulse();
    ld_n = 1'b0;
    @(posedge sclk); @(negedge sclk);
    ld_n = 1'b1;
  endtask

  task automatic t_reset();
    cs_n = 1'b1; ld_n = 1'b1; clr_n = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge sclk);
    chk_code("R1", 0);
    chk("R7", "shift_viol", int'(shift_viol), 0);
    clr_n = 1'b1;
    #1 chk_code("R6", 0);
    @(posedge sclk); @(negedge sclk);
    chk_code("R6", 0);
  endtask

  task automatic t_load();
    shift_word(12'hA5C);
    chk_code("R5", 0);
    ld_n = 1'b0;
    #1 chk_code("R4", 'hA5C);
    @(posedge sclk); @(negedge sclk);
    ld_n = 1'b1;
    chk_code("R2", 'hA5C);
  endtask

  task automatic t_deselect();
    cs_n = 1'b1;
    for (int i = 0; i < W; i++) begin
      sdi = i[0];
      @(posedge sclk); @(negedge sclk);
    end
    load_pulse();
    chk_code("R3", 'hA5C);
  endtask

  task automatic t_hold();
    shift_word(12'h123);
    chk_code("R5", 'hA5C);
    load_pulse();
    chk_code("R2", 'h123);
  endtask

  task automatic t_scale();
    shift_word(12'hFFF); load_pulse(); chk_code("R8", 4095);
    shift_word(12'h800); load_pulse(); chk_code("R8", 2048);
    shift_word(12'h7FF); load_pulse(); chk_code("R8", 2047);
    shift_word(12'h000); load_pulse(); chk_code("R8", 0);
  endtask

  task automatic t_viol();
    ld_n = 1'b0; cs_n = 1'b0; sdi = 1'b1;
    @(posedge sclk); @(negedge sclk);
    chk_code("R7", 1);
    chk("R7", "shift_viol", int'(shift_viol), 1);
    cs_n = 1'b1;
    @(posedge sclk); @(negedge sclk);
    chk("R7", "shift_viol", int'(shift_viol), 0);
    chk_code("R4", 1);
    ld_n = 1'b1;
  endtask

  task automatic t_clear();
    shift_word(12'hFFF); load_pulse();
    chk_code("R5", 4095);
    clr_n = 1'b0;
    #1 chk_code("R1", 0);
    cs_n = 1'b0; sdi = 1'b1;
    @(posedge sclk); @(negedge sclk);
    cs_n = 1'b1;
    chk_code("R1", 0);
    chk("R7", "shift_viol", int'(shift_viol), 0);
    clr_n = 1'b1;
    #1 chk_code("R6", 0);
    @(posedge sclk); @(negedge sclk);
    chk_code("R6", 0);
    ld_n = 1'b0;
    #1 chk_code("R4", 4095);
    clr_n = 1'b0;
    #1 chk_code("R9", 0);
    @(posedge sclk); @(negedge sclk);
    chk_code("R9", 0);
    clr_n = 1'b1;
    #1 chk_code("R9", 4095);
    @(posedge sclk); @(negedge sclk);
    ld_n = 1'b1;
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_deselect();
    t_hold();
    t_scale();
    t_viol();
    t_clear();
    repeat (2) @(negedge sclk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule